// File: doc/BRIEF.md
# Unique ID Copy Validator

This block checks the redundant identifier page of a serial NAND device as the host reads it out. The page carries sixteen back-to-back records of thirty-two bytes each. In every record the second sixteen bytes should be the bitwise inverse of the first sixteen. The block consumes the page as a byte stream that starts at column 0. It buffers the first half of each record and tests every byte of the second half against its partner as it arrives. It reports the first record that passes.

When a record passes, the block latches the sixteen identifier bytes, pulses a done strobe and reports the record number. Every byte after that is consumed and thrown away. If no record passes, done and an error level come up together after the final byte. A start pulse re-arms the block for a fresh page.

The input uses valid/ready. `in_ready` falls only in a cycle where `start` is high, and a byte offered in that cycle is not taken. In every other cycle a byte is taken whenever `in_valid` is high. Because there is no other back-pressure, the source may stream at full rate.

Top module: `uid_copy_checker`

## Requirements
- R1: While reset is asserted and right after it, `done`, `error`, `copy_idx` and `id_out` are all zero and `in_ready` is high. The block is armed to take byte 0 of record 0.
- R2: A byte is taken on each rising clock edge where `in_valid` and `in_ready` are both high. Taken bytes are counted as page positions 0 to 511, and record c occupies positions 32c to 32c+31.
- R3: A record passes when, for every i from 0 to 15, its byte i XOR its byte i+16 equals FFh. In the cycle after the record's byte 31 is taken, `done` is high, `error` is low and `copy_idx` holds the record number. `id_out` then holds the record's bytes 0 to 15, with byte i in bits 8i+7 down to 8i.
- R4: A single flipped bit in either half of any pair makes that record fail. Checking then continues with the next record.
- R5: Only the first passing record is reported. Bytes taken after it cause no further `done`, and `id_out` and `copy_idx` do not change.
- R6: If all sixteen records fail, `done` and `error` are both high in the cycle after position 511 is taken. `id_out` and `copy_idx` keep their earlier values, and `error` stays high until `start`.
- R7: `start` clears the position count and `error`. The next byte taken after `start` is position 0. `id_out` and `copy_idx` are kept.
- R8: Cycles with `in_valid` low do not advance the position and do not affect the result.
- R9: `done` is high for exactly one cycle per page result.
- R10: `in_ready` is low in a cycle where `start` is high, and a byte offered in that cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Re-arm pulse for a new page |
| in_valid | input | 1 | A page byte is offered |
| in_ready | output | 1 | The block takes the offered byte |
| in_data | input | 8 | Page byte |
| done | output | 1 | One-cycle result strobe |
| error | output | 1 | No record passed; held until start |
| copy_idx | output | 4 | Number of the passing record |
| id_out | output | 128 | Identifier bytes of the passing record, byte 0 in the low bits |

## Verification
The assertions assume `start` is a pulse and that the source always begins a page at column 0. Under those assumptions a single `done` follows each `start`, and `id_out` may change only in a passing `done` cycle. The stimulus always sends whole 512-byte pages after reset or `start`. The one exception is a deliberately truncated page, which is always followed by `start` before a new page begins. Gaps in `in_valid` and bytes offered alongside `start` are used only where the requirements say they are dropped.

// File: rtl/uidchk_pkg.sv
package uidchk_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [0:0] {
    SCAN_ST = 1'b0,
    HELD_ST = 1'b1
  } scan_state_e;

  function automatic logic halves_match(input logic [BYTE_W-1:0] a,
                                        input logic [BYTE_W-1:0] b);
    return &(a ^ b);
  endfunction
endpackage

// File: rtl/uid_half_buffer.sv
module uid_half_buffer #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [W-1:0]   wr_data,
  input  logic [IW-1:0]  rd_idx,
  output logic [W-1:0]   rd_data,
  output logic [N*W-1:0] flat
);
  logic [W-1:0] slot [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[g] <= '0;
      end else if (wr_en && (wr_idx == IW'(g))) begin
        slot[g] <= wr_data;
      end
    end
    assign flat[g*W +: W] = slot[g];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < N; k++) begin
      if (rd_idx == IW'(k)) rd_data = slot[k];
    end
  end
endmodule

// File: rtl/uid_pair_check.sv
module uid_pair_check
  import uidchk_pkg::*;
(
  input  logic [BYTE_W-1:0] stored,
  input  logic [BYTE_W-1:0] incoming,
  output logic              match
);
  always_comb match = halves_match(stored, incoming);
endmodule

// File: rtl/uid_seq_ctrl.sv
module uid_seq_ctrl
  import uidchk_pkg::*;
#(
  parameter int unsigned HALF   = 16,
  parameter int unsigned COPIES = 16,
  localparam int unsigned OFF_W = $clog2(2*HALF),
  localparam int unsigned IW    = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int unsigned CW    = (COPIES > 1) ? $clog2(COPIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          beat,
  input  logic          pair_match,
  output logic          store_en,
  output logic [IW-1:0] wr_idx,
  output logic [IW-1:0] rd_idx,
  output logic          pass_ev,
  output logic          done,
  output logic          error,
  output logic [CW-1:0] copy_idx
);
  localparam logic [OFF_W-1:0] LAST_OFF  = OFF_W'(2*HALF-1);
  localparam logic [OFF_W-1:0] HALF_OFF  = OFF_W'(HALF);
  localparam logic [CW-1:0]    LAST_COPY = CW'(COPIES-1);

  scan_state_e      state_q;
  logic [OFF_W-1:0] off_q;
  logic [CW-1:0]    cpy_q;
  logic             bad_q;
  logic             active, second, rec_end, fail_all_ev;

  always_comb begin
    active      = beat && (state_q == SCAN_ST);
    second      = off_q >= HALF_OFF;
    rec_end     = active && (off_q == LAST_OFF);
    pass_ev     = rec_end && !bad_q && pair_match;
    fail_all_ev = rec_end && !pass_ev && (cpy_q == LAST_COPY);
    store_en    = active && !second;
    wr_idx      = IW'(off_q);
    rd_idx      = IW'(off_q - HALF_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SCAN_ST;
      off_q    <= '0;
      cpy_q    <= '0;
      bad_q    <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      copy_idx <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state_q <= SCAN_ST;
        off_q   <= '0;
        cpy_q   <= '0;
        bad_q   <= 1'b0;
        error   <= 1'b0;
      end else if (active) begin
        if (off_q == LAST_OFF) begin
          off_q <= '0;
          bad_q <= 1'b0;
          cpy_q <= (cpy_q == LAST_COPY) ? '0 : cpy_q + 1'b1;
        end else begin
          off_q <= off_q + 1'b1;
          bad_q <= bad_q | (second && !pair_match);
        end
        if (pass_ev) begin
          state_q  <= HELD_ST;
          done     <= 1'b1;
          copy_idx <= cpy_q;
        end
        if (fail_all_ev) begin
          state_q <= HELD_ST;
          done    <= 1'b1;
          error   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uid_copy_checker.sv
module uid_copy_checker
  import uidchk_pkg::*;
#(
  parameter int unsigned HALF   = 16,
  parameter int unsigned COPIES = 16,
  localparam int unsigned IW    = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int unsigned CW    = (COPIES > 1) ? $clog2(COPIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [BYTE_W-1:0]      in_data,
  output logic                   done,
  output logic                   error,
  output logic [CW-1:0]          copy_idx,
  output logic [HALF*BYTE_W-1:0] id_out
);
  logic                   beat, store_en, pair_match, pass_ev;
  logic [IW-1:0]          wr_idx, rd_idx;
  logic [BYTE_W-1:0]      partner;
  logic [HALF*BYTE_W-1:0] held;

  assign in_ready = !start;
  assign beat     = in_valid && in_ready;

  uid_seq_ctrl #(.HALF(HALF), .COPIES(COPIES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .beat(beat),
    .pair_match(pair_match), .store_en(store_en), .wr_idx(wr_idx),
    .rd_idx(rd_idx), .pass_ev(pass_ev), .done(done), .error(error),
    .copy_idx(copy_idx)
  );

  uid_half_buffer #(.W(BYTE_W), .N(HALF)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(store_en), .wr_idx(wr_idx),
    .wr_data(in_data), .rd_idx(rd_idx), .rd_data(partner), .flat(held)
  );

  uid_pair_check u_cmp (
    .stored(partner), .incoming(in_data), .match(pair_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       id_out <= '0;
    else if (pass_ev) id_out <= held;
  end
endmodule

// File: rtl/uid_copy_checker_sva.sv
module uid_copy_checker_sva #(
  parameter int unsigned IDW = 128,
  parameter int unsigned CW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           done,
  input logic           error,
  input logic [CW-1:0]  copy_idx,
  input logic [IDW-1:0] id_out
);
  logic fin_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fin_q <= 1'b0;
    else if (start) fin_q <= 1'b0;
    else if (done)  fin_q <= 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && !start) |-> !done); // R5
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done); // R6
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error); // R6
  AST_ID_ON_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(id_out) |-> (done && !error)); // R3
  AST_IDX_ON_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(copy_idx) |-> (done && !error)); // R3
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!error && !done)); // R7
endmodule

bind uid_copy_checker uid_copy_checker_sva #(.IDW(HALF*8), .CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
  .copy_idx(copy_idx), .id_out(id_out)
);

// File: tb/sim_uid_copy_checker.sv
module sim_uid_copy_checker;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   in_data = '0;
  logic         done, error;
  logic [3:0]   copy_idx;
  logic [127:0] id_out;

  int checks = 0;
  int failures = 0;
  int done_cnt, done_pos;
  logic err_at_done;

  always #2.5 clk = ~clk;

  uid_copy_checker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .done(done), .error(error),
    .copy_idx(copy_idx), .id_out(id_out)
  );

  task automatic check(input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] id_byte(input int i, input int seed);
    return 8'((seed * 37 + i * 13 + 5) & 255);
  endfunction

  function automatic logic [127:0] id_word(input int seed);
    logic [127:0] w;
    for (int i = 0; i < 16; i++) w[i*8 +: 8] = id_byte(i, seed);
    return w;
  endfunction

  // Records below first_good carry one flipped bit; first_good = 16 means all bad.
  function automatic logic [7:0] page_byte(input int k, input int first_good,
                                           input int seed);
    int c, o, i;
    logic [7:0] v;
    c = k / 32; o = k % 32; i = o % 16;
    v = (o < 16) ? id_byte(i, seed) : ~id_byte(i, seed);
    if (c < first_good && i == ((c * 5 + seed) % 16) &&
        ((o >= 16) == (((c + seed) & 1) == 1)))
      v = v ^ (8'd1 << ((c + seed) % 8));
    return v;
  endfunction

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'hA5;
  endtask

  task automatic send_page(input int first_good, input int seed, input int gap,
                           input int nbytes);
    done_cnt = 0; done_pos = -1; err_at_done = 1'b0;
    for (int k = 0; k < nbytes; k++) begin
      push(page_byte(k, first_good, seed));
      if (done) begin
        done_cnt++;
        if (done_pos < 0) begin done_pos = k; err_at_done = error; end
      end
      if (gap != 0 && (k % 3) == 2) begin
        repeat (gap) begin
          @(negedge clk);
          if (done) done_cnt++;
        end
      end
    end
  endtask

  task automatic pulse_start(input logic with_byte);
    start = 1'b1;
    in_valid = with_byte;
    in_data = 8'h00;
    #0.1;
    check("R10 ready low during start", 128'(in_ready), 128'(1'b0));
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [127:0] prev_id;
    logic [3:0]   prev_idx;
    #1;
    check("R1 done in reset", 128'(done), 128'(0));
    check("R1 error in reset", 128'(error), 128'(0));
    check("R1 id in reset", id_out, 128'(0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idx after reset", 128'(copy_idx), 128'(0));
    check("R1 ready after reset", 128'(in_ready), 128'(1));

    // R3 R4 R8: sweep the position of the first passing record
    for (int p = 0; p < 16; p++) begin
      if (p != 0) pulse_start(1'b0);
      send_page(p, p + 1, (p % 2) ? 1 : 0, 512);
      check("R9 R5 single done", 128'(done_cnt), 128'(1));
      check("R3 R4 done position", 128'(done_pos), 128'(32 * p + 31));
      check("R3 error low on pass", 128'(err_at_done), 128'(0));
      check("R3 id bytes", id_out, id_word(p + 1));
      check("R3 copy index", 128'(copy_idx), 128'(p));
    end

    // R5: extra bytes after the result change nothing
    prev_id = id_out; prev_idx = copy_idx;
    send_page(0, 9, 0, 40);
    check("R5 no done after result", 128'(done_cnt), 128'(0));
    check("R5 id kept", id_out, prev_id);
    check("R5 idx kept", 128'(copy_idx), 128'(prev_idx));

    // R6: every record fails
    pulse_start(1'b0);
    send_page(16, 3, 0, 512);
    check("R6 single done", 128'(done_cnt), 128'(1));
    check("R6 done at 511", 128'(done_pos), 128'(511));
    check("R6 error with done", 128'(err_at_done), 128'(1));
    check("R6 id kept", id_out, prev_id);
    check("R6 idx kept", 128'(copy_idx), 128'(prev_idx));
    repeat (4) @(negedge clk);
    check("R6 error held", 128'(error), 128'(1));

    // R7 R10: start mid-page with a byte offered alongside it
    pulse_start(1'b0);
    check("R7 error cleared", 128'(error), 128'(0));
    send_page(0, 20, 0, 45);
    pulse_start(1'b1);
    send_page(2, 21, 0, 512);
    check("R7 R10 realigned done", 128'(done_pos), 128'(95));
    check("R7 R10 id", id_out, id_word(21));
    check("R7 R10 idx", 128'(copy_idx), 128'(2));
    check("R2 R9 one done", 128'(done_cnt), 128'(1));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule